// File: doc/BRIEF.md
# Negative-Delta-V Termination Detector

This block judges the periodic cell-voltage readings taken while a nickel cell is fast-charged. Each reading carries two unsigned millivolt values: the voltage with charge current flowing (loaded) and the voltage with the current switched off (open). For every accepted reading the block returns one verdict, registered one cycle later: continue, done (charge complete, move to top-off) or fail (reject the cell).

Completion is found in two ways. The first is a drop of the open voltage below the highest open voltage seen since fast-charge began. The second is a plateau, where no new highest value appears for a programmable number of minutes. Both are masked during a startup hold-off counted in minutes from the start pulse. Rejection covers a loaded-to-open voltage gap above a programmable impedance threshold, and any open voltage above a fixed ceiling. A one-cycle start pulse at fast-charge entry clears all history. A one-cycle minute tick drives both timers.

Top module: `ndv_term_det`

## Requirements
- R1: The highest open voltage (v_open_i) of all accepted samples since the last start pulse is kept as the peak, and peak-based decisions use that retained value.
- R2: Once the hold-off has ended, a sample whose open voltage is more than DROP_MV (2) mV below the peak yields done. A drop of exactly DROP_MV yields continue.
- R3: Once the hold-off has ended, a sample that does not raise the peak yields done when FLAT_MIN (16) minute ticks have passed since the peak was last raised.
- R4: Neither completion criterion yields done until HOLD_MIN (4) minute ticks have been received since the last start pulse.
- R5: A sample whose loaded voltage exceeds its open voltage by more than imp_thr_i yields fail. A gap equal to the threshold, or a loaded voltage at or below the open voltage, does not.
- R6: A sample whose open voltage is above OPEN_MAX_MV (1650) yields fail. Exactly 1650 does not.
- R7: When a sample meets a fail condition and a done condition together, the verdict is fail only.
- R8: A start pulse clears the peak to zero and resets both minute timers. A sample presented in the same cycle as start is dropped: it gives no result and does not update the peak.
- R9: A sample strictly above the peak restarts the plateau timer and does not itself yield done through the plateau rule. A sample equal to the peak does not restart the timer.
- R10: res_valid_o is high exactly in the cycle after an accepted sample. res_done_o and res_fail_o are only high together with res_valid_o and are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Fast-charge entry pulse, clears history |
| min_tick_i | input | 1 | One-cycle pulse per elapsed minute |
| smp_valid_i | input | 1 | Sample strobe |
| v_load_i | input | VW | Cell voltage under charge, mV |
| v_open_i | input | VW | Cell voltage without charge current, mV |
| imp_thr_i | input | VW | Impedance threshold on the loaded-to-open gap, mV |
| res_valid_o | output | 1 | Verdict present |
| res_done_o | output | 1 | Charge complete |
| res_fail_o | output | 1 | Cell rejected |

## Verification
Every verdict is due in the cycle after the edge that captures its sample. The check sees it at the falling edge one full clock after the strobe was driven. A minute tick or start pulse takes effect at the edge that captures it, so the next sample already sees it. The driver drives inputs on falling edges and queues the expected verdict when it drives the sample. The monitor pops the queue on the falling edge where res_valid_o is high, and it reports a verdict that arrives with the queue empty, as well as any item still left in the queue at the end.

// File: rtl/ndv_pkg.sv
package ndv_pkg;
  typedef enum logic [1:0] {
    VERD_CONT = 2'd0,
    VERD_DONE = 2'd1,
    VERD_FAIL = 2'd2
  } verdict_e;
endpackage

// File: rtl/ndv_tick_cnt.sv
module ndv_tick_cnt #(
  parameter int LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic reached_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i)                 cnt_q <= '0;
    else if (tick_i && cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign reached_o = (cnt_q == LIM);
endmodule

// File: rtl/ndv_peak_trk.sv
module ndv_peak_trk #(
  parameter int VW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          smp_acc_i,
  input  logic [VW-1:0] v_open_i,
  output logic [VW-1:0] peak_o,
  output logic          new_peak_o
);
  logic [VW-1:0] peak_q;

  assign new_peak_o = smp_acc_i && (v_open_i > peak_q);
  assign peak_o     = peak_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         peak_q <= '0;
    else if (clr_i)      peak_q <= '0;
    else if (new_peak_o) peak_q <= v_open_i;
  end
endmodule

// File: rtl/ndv_judge.sv
module ndv_judge
  import ndv_pkg::*;
#(
  parameter int VW          = 12,
  parameter int DROP_MV     = 2,
  parameter int OPEN_MAX_MV = 1650
) (
  input  logic [VW-1:0] v_load_i,
  input  logic [VW-1:0] v_open_i,
  input  logic [VW-1:0] imp_thr_i,
  input  logic [VW-1:0] peak_i,
  input  logic          new_peak_i,
  input  logic          hold_ok_i,
  input  logic          flat_ok_i,
  output verdict_e      verdict_o
);
  localparam logic [VW-1:0] DROP = VW'(DROP_MV);
  localparam logic [VW-1:0] CEIL = VW'(OPEN_MAX_MV);

  logic imp_bad, ceil_bad, drop_hit, flat_hit;

  always_comb begin
    imp_bad  = (v_load_i > v_open_i) && ((v_load_i - v_open_i) > imp_thr_i);
    ceil_bad = v_open_i > CEIL;
    drop_hit = (peak_i > v_open_i) && ((peak_i - v_open_i) > DROP);
    flat_hit = flat_ok_i && !new_peak_i;
    if (imp_bad || ceil_bad)                    verdict_o = VERD_FAIL;
    else if (hold_ok_i && (drop_hit || flat_hit)) verdict_o = VERD_DONE;
    else                                        verdict_o = VERD_CONT;
  end
endmodule

// File: rtl/ndv_term_det.sv
module ndv_term_det
  import ndv_pkg::*;
#(
  parameter int VW          = 12,
  parameter int DROP_MV     = 2,
  parameter int FLAT_MIN    = 16,
  parameter int HOLD_MIN    = 4,
  parameter int OPEN_MAX_MV = 1650
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          min_tick_i,
  input  logic          smp_valid_i,
  input  logic [VW-1:0] v_load_i,
  input  logic [VW-1:0] v_open_i,
  input  logic [VW-1:0] imp_thr_i,
  output logic          res_valid_o,
  output logic          res_done_o,
  output logic          res_fail_o
);
  logic          smp_acc;
  logic [VW-1:0] peak;
  logic          new_peak, hold_ok, flat_ok;
  verdict_e      verdict;

  // start wins over a coincident sample
  assign smp_acc = smp_valid_i && !start_i;

  ndv_peak_trk #(.VW(VW)) u_peak (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (start_i),
    .smp_acc_i  (smp_acc),
    .v_open_i   (v_open_i),
    .peak_o     (peak),
    .new_peak_o (new_peak)
  );

  ndv_tick_cnt #(.LIMIT(HOLD_MIN)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (start_i),
    .tick_i    (min_tick_i),
    .reached_o (hold_ok)
  );

  ndv_tick_cnt #(.LIMIT(FLAT_MIN)) u_flat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (start_i || new_peak),
    .tick_i    (min_tick_i),
    .reached_o (flat_ok)
  );

  ndv_judge #(.VW(VW), .DROP_MV(DROP_MV), .OPEN_MAX_MV(OPEN_MAX_MV)) u_judge (
    .v_load_i   (v_load_i),
    .v_open_i   (v_open_i),
    .imp_thr_i  (imp_thr_i),
    .peak_i     (peak),
    .new_peak_i (new_peak),
    .hold_ok_i  (hold_ok),
    .flat_ok_i  (flat_ok),
    .verdict_o  (verdict)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_done_o  <= 1'b0;
      res_fail_o  <= 1'b0;
    end else begin
      res_valid_o <= smp_acc;
      res_done_o  <= smp_acc && (verdict == VERD_DONE);
      res_fail_o  <= smp_acc && (verdict == VERD_FAIL);
    end
  end
endmodule

// File: rtl/ndv_term_det_chk.sv
module ndv_term_det_chk #(
  parameter int VW          = 12,
  parameter int HOLD_MIN    = 4,
  parameter int OPEN_MAX_MV = 1650
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          min_tick_i,
  input logic          smp_valid_i,
  input logic [VW-1:0] v_open_i,
  input logic          res_valid_o,
  input logic          res_done_o,
  input logic          res_fail_o
);
  localparam int CW = $clog2(HOLD_MIN + 1);
  localparam logic [CW-1:0] HLIM = CW'(HOLD_MIN);
  localparam logic [VW-1:0] CEIL = VW'(OPEN_MAX_MV);

  logic [CW-1:0] ticks_seen;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            ticks_seen <= '0;
    else if (start_i)                       ticks_seen <= '0;
    else if (min_tick_i && ticks_seen != HLIM) ticks_seen <= ticks_seen + 1'b1;
  end

  assert_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(res_done_o && res_fail_o));
  assert_flag_needs_valid_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_done_o || res_fail_o) |-> res_valid_o);
  assert_valid_follows_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && !start_i) |=> res_valid_o);
  assert_start_drops_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !res_valid_o);
  assert_open_ceiling_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && !start_i && v_open_i > CEIL) |=> res_fail_o);
  assert_holdoff_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_done_o |-> ($past(ticks_seen) == HLIM));
endmodule

bind ndv_term_det ndv_term_det_chk #(
  .VW(VW), .HOLD_MIN(HOLD_MIN), .OPEN_MAX_MV(OPEN_MAX_MV)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .min_tick_i  (min_tick_i),
  .smp_valid_i (smp_valid_i),
  .v_open_i    (v_open_i),
  .res_valid_o (res_valid_o),
  .res_done_o  (res_done_o),
  .res_fail_o  (res_fail_o)
);

// File: tb/ndv_term_det_tb.sv
`timescale 1ns/1ps
module ndv_term_det_tb;
  localparam int VW = 12;
  localparam int DROP = 2, FLAT = 16, HOLD = 4, CEIL = 1650;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, tick = 1'b0, sv = 1'b0;
  logic [VW-1:0] vl = '0, vo = '0, thr = '0;
  logic rv, rd, rf;

  int n_test = 0, n_fail = 0;
  bit finished = 0;

  logic [1:0] exp_q[$];
  string      tag_q[$];

  int m_peak = 0, m_hold = 0, m_flat = 0;

  always #4 clk = ~clk;

  ndv_term_det #(.VW(VW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .min_tick_i(tick),
    .smp_valid_i(sv), .v_load_i(vl), .v_open_i(vo), .imp_thr_i(thr),
    .res_valid_o(rv), .res_done_o(rd), .res_fail_o(rf)
  );

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_test++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {done,fail} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && rv) begin
      if (exp_q.size() == 0) begin
        n_test++; n_fail++;
        $display("FAIL R10: unexpected verdict actual=%b expected=none", {rd, rf});
      end else begin
        logic [1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, {rd, rf}, e);
      end
    end
  end

  task automatic do_start();
    start = 1'b1;
    m_peak = 0; m_hold = 0; m_flat = 0;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic do_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      if (m_hold < HOLD) m_hold++;
      if (m_flat < FLAT) m_flat++;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic do_smp(input int l, input int o, input int t, input string tag);
    bit f, d, newp;
    vl = VW'(l); vo = VW'(o); thr = VW'(t); sv = 1'b1;
    f = ((l > o) && (l - o > t)) || (o > CEIL);
    newp = o > m_peak;
    d = !f && (m_hold >= HOLD) &&
        ((m_peak - o > DROP) || (m_flat >= FLAT && !newp));
    exp_q.push_back({d, f});
    tag_q.push_back(tag);
    if (newp) begin m_peak = o; m_flat = 0; end
    @(negedge clk);
    sv = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      n_test++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_test, n_fail);
      $finish;
    end
  end

  initial begin
    #1;
    chk("reset", {rv, rd}, 2'b00);
    chk("reset fail flag", {1'b0, rf}, 2'b00);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R4
    do_start();
    do_smp(1400, 1400, 100, "R1 first peak");
    do_smp(1390, 1390, 100, "R4 drop masked in hold-off");
    do_ticks(HOLD);
    do_smp(1398, 1398, 100, "R2 drop equal to limit");
    do_smp(1397, 1397, 100, "R2 drop past limit, R1 peak kept");
    // R5
    do_smp(1500, 1400, 100, "R5 gap equal to threshold");
    do_smp(1501, 1400, 100, "R5 gap over threshold");
    do_smp(1300, 1400, 32,  "R5 loaded below open");
    // R6
    do_smp(1650, 1650, 100, "R6 open at ceiling");
    do_smp(1651, 1651, 100, "R6 open above ceiling");
    // R7: drop from 1651 and impedance fail together
    do_smp(1700, 1500, 50, "R7 fail over done");

    // R8 clear
    do_start();
    do_smp(1200, 1200, 100, "R8 after start hold-off");
    do_ticks(HOLD);
    do_smp(1199, 1199, 100, "R8 small drop from new peak");
    do_smp(1197, 1197, 100, "R8 peak cleared by start");

    // R8 coincident sample dropped
    start = 1'b1; sv = 1'b1; vl = 12'd1600; vo = 12'd1600; thr = 12'd100;
    m_peak = 0; m_hold = 0; m_flat = 0;
    @(negedge clk);
    start = 1'b0; sv = 1'b0;
    chk("R8 coincident sample no result", {rv, 1'b0}, 2'b00);
    do_ticks(HOLD);
    do_smp(1200, 1200, 100, "R8 coincident sample not peak");

    // R3 flat
    do_start();
    do_smp(1300, 1300, 100, "R3 set peak");
    do_ticks(FLAT);
    do_smp(1300, 1300, 100, "R3 flat timeout");

    // R9 flat restart
    do_start();
    do_smp(1300, 1300, 100, "R9 set peak");
    do_ticks(FLAT);
    do_smp(1301, 1301, 100, "R9 new peak no flat done");
    do_ticks(FLAT - 1);
    do_smp(1301, 1301, 100, "R9 equal sample before timeout");
    do_ticks(1);
    do_smp(1301, 1301, 100, "R9 flat after restart");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_test++; n_fail++;
      $display("FAIL R10: missing verdicts actual=%0d expected=0", exp_q.size());
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_test, n_fail);
    $finish;
  end
endmodule